// File: doc/BRIEF.md
# Core Timer with Watchdog

A free-running timer chain for a small 8-bit microcontroller. The operating clock is first divided by a prescaler. The prescaler feeds an 8-bit counter that software can read at any time. Further divider stages above the counter provide a periodic real-time tick, whose period is picked by a 2-bit rate select. A computer-operating-properly watchdog counts eight of those ticks. Software must service it before the count runs out, or the block raises a one-cycle reset request.

Servicing the watchdog clears only its own divide-by-eight stage. The prescaler, the readable counter and the tick dividers keep their phase. As a result, a timeout falls between seven and eight tick periods after the last service. The block is reached through a small register bus with a write strobe and a combinational read path. The same bus writes the rate select and services the watchdog. When the watchdog expires, the whole block returns to its reset state in the cycle where the reset request is raised.

Top module: `core_timer_wdog`

## Requirements
- R1: A chain counter advances by one on every clock edge and returns to zero on reset. The readable counter is bits [PRE_W +: CNT_W] of this chain, so it advances once every 2^PRE_W clocks (4 by default). It is read zero-extended on `bus_rdata_o` when `bus_addr_i` is 14'h0009, and it reads 0 during and right after reset.
- R2: `ovf_o` is high for exactly one clock in each counter period. That clock is the one in which the low PRE_W+CNT_W chain bits are all ones, so the counter reads 0 in the next cycle.
- R3: The rate select lives in bits [1:0] of the register at 14'h0008 and reads back there, with 0 in bits [7:2]. It resets to 0. `rti_tick_o` is high for one clock in the cycle where the low PRE_W+CNT_W+RTI_W+sel chain bits are all ones. The tick period is therefore 2^(PRE_W+CNT_W+RTI_W+sel) clocks, which is 2^14, 2^15, 2^16 or 2^17 for sel = 0..3 at the default sizes.
- R4: The watchdog stage counts edges at which `rti_tick_o` is high. On the eighth counted tick since reset or the last service, `cop_rst_o` is high for exactly one cycle, starting right after that edge.
- R5: A write to 14'h3FF0 with data bit 0 equal to 0 services the watchdog by clearing only the divide-by-eight stage. The counter and the tick dividers keep counting undisturbed. A write there with bit 0 equal to 1 has no effect.
- R6: If a service write and a counted tick land on the same edge, the service wins and that tick is not counted. This also holds when that tick would have been the expiring one, in which case no pulse is raised.
- R7: A write of a new rate select takes effect from the next tap of the new rate. It does not clear or change the watchdog stage.
- R8: On the edge that raises `cop_rst_o`, the chain, the counter, the watchdog stage and the rate select all return to 0. Counting then restarts as if from reset.
- R9: Writes to the counter address 14'h0009 are ignored. Reads of 14'h3FF0 and of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Operating clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 14 | Register bus address |
| bus_wr_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Combinational read data for `bus_addr_i` |
| ovf_o | output | 1 | Counter overflow indication, one clock per counter period |
| rti_tick_o | output | 1 | Real-time tick at the selected rate |
| cop_rst_o | output | 1 | Watchdog reset request, one-cycle pulse |

## Verification
A service write and a counted tick can fall on the same clock edge, and the service must win. The bench provokes this by placing the service write on the edge that would otherwise be the watchdog's eighth, expiring tick. At that edge the chain sits at a multiple of the tap period. The collision is judged at the outputs: no pulse may appear at that edge, and the pulse must instead arrive exactly eight full tap periods later. Every cycle also checks the counter, the overflow and the tick, which shows that the chain was not disturbed.

// File: rtl/core_timer_pkg.sv
package core_timer_pkg;
  localparam int ADDR_W = 14;
  localparam int DATA_W = 8;
  localparam int RATE_W = 2;
  localparam int NUM_RATES = 1 << RATE_W;
  localparam int COP_W = 3;  // divide-by-eight stage

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 14'h0008;
  localparam logic [ADDR_W-1:0] CNT_ADDR  = 14'h0009;
  localparam logic [ADDR_W-1:0] CLR_ADDR  = 14'h3FF0;

  typedef logic [RATE_W-1:0] rate_t;
endpackage

// File: rtl/ct_chain.sv
module ct_chain #(
  parameter int PRE_W = 2,
  parameter int CNT_W = 8,
  parameter int RTI_W = 4,
  localparam int TOT_W = PRE_W + CNT_W + RTI_W + core_timer_pkg::RATE_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_clr_i,
  output logic [TOT_W-1:0] chain_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [TOT_W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         chain_q <= '0;
    else if (sync_clr_i) chain_q <= '0;
    else                 chain_q <= chain_q + 1'b1;
  end

  assign chain_o = chain_q;
  assign cnt_o   = chain_q[PRE_W +: CNT_W];
  assign ovf_o   = &chain_q[PRE_W+CNT_W-1:0];
endmodule

// File: rtl/ct_rti_tap.sv
module ct_rti_tap #(
  parameter int BASE_W = 14,
  parameter int TOT_W  = 18
) (
  input  logic [TOT_W-1:0]           chain_i,
  input  core_timer_pkg::rate_t      sel_i,
  output logic                       tick_o
);
  import core_timer_pkg::*;
  logic [NUM_RATES-1:0] hit;

  for (genvar r = 0; r < NUM_RATES; r++) begin : g_tap
    assign hit[r] = &chain_i[BASE_W+r-1:0];
  end

  assign tick_o = hit[sel_i];
endmodule

// File: rtl/ct_cop.sv
module ct_cop #(
  parameter int COP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic             expire_o,
  output logic             cop_rst_o,
  output logic [COP_W-1:0] cnt_o
);
  logic [COP_W-1:0] cnt_q;
  logic             rst_q;

  // service has priority over a coincident tick
  assign expire_o = tick_i && !clr_i && (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= expire_o;
      if (clr_i || expire_o) cnt_q <= '0;
      else if (tick_i)       cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cop_rst_o = rst_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/core_timer_wdog.sv
module core_timer_wdog
  import core_timer_pkg::*;
#(
  parameter int PRE_W = 2,
  parameter int CNT_W = 8,
  parameter int RTI_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              ovf_o,
  output logic              rti_tick_o,
  output logic              cop_rst_o
);
  localparam int BASE_W = PRE_W + CNT_W + RTI_W;
  localparam int TOT_W  = BASE_W + RATE_W + 1;

  logic [TOT_W-1:0] chain_w;
  logic [CNT_W-1:0] cnt_w;
  logic [COP_W-1:0] cop_cnt_w;
  logic             expire_w;
  logic             clr_w;
  logic             ctrl_wr_w;
  rate_t            sel_q;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:RATE_W];
  assign clr_w     = bus_wr_i && (bus_addr_i == CLR_ADDR) && !bus_wdata_i[0];
  assign ctrl_wr_w = bus_wr_i && (bus_addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sel_q <= '0;
    else if (expire_w)  sel_q <= '0;
    else if (ctrl_wr_w) sel_q <= bus_wdata_i[RATE_W-1:0];
  end

  ct_chain #(.PRE_W(PRE_W), .CNT_W(CNT_W), .RTI_W(RTI_W)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_clr_i(expire_w),
    .chain_o   (chain_w),
    .cnt_o     (cnt_w),
    .ovf_o     (ovf_o)
  );

  ct_rti_tap #(.BASE_W(BASE_W), .TOT_W(TOT_W)) u_tap (
    .chain_i(chain_w),
    .sel_i  (sel_q),
    .tick_o (rti_tick_o)
  );

  ct_cop #(.COP_W(COP_W)) u_cop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (rti_tick_o),
    .clr_i    (clr_w),
    .expire_o (expire_w),
    .cop_rst_o(cop_rst_o),
    .cnt_o    (cop_cnt_w)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      CNT_ADDR:  bus_rdata_o = DATA_W'(cnt_w);
      CTRL_ADDR: bus_rdata_o = DATA_W'(sel_q);
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/core_timer_wdog_chk.sv
module core_timer_wdog_chk #(
  parameter int CNT_W = 8,
  parameter int COP_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic             ovf_i,
  input logic             tick_i,
  input logic             clr_i,
  input logic             expire_i,
  input logic             cop_rst_i,
  input logic [COP_W-1:0] cop_cnt_i
);
  assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !expire_i |=> (cnt_i == $past(cnt_i)) || (cnt_i == CNT_W'($past(cnt_i) + 1'b1)));

  assert_ovf_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> (cnt_i == '0));

  assert_tick_in_ovf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> ovf_i);

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_rst_i |=> !cop_rst_i);

  assert_clear_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !cop_rst_i);

  assert_cop_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cop_cnt_i));

  assert_pulse_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cop_rst_i |-> (cnt_i == '0) && (cop_cnt_i == '0));
endmodule

bind core_timer_wdog core_timer_wdog_chk #(.CNT_W(CNT_W), .COP_W(core_timer_pkg::COP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_i    (cnt_w),
  .ovf_i    (ovf_o),
  .tick_i   (rti_tick_o),
  .clr_i    (clr_w),
  .expire_i (expire_w),
  .cop_rst_i(cop_rst_o),
  .cop_cnt_i(cop_cnt_w)
);

// File: tb/core_timer_wdog_bench.sv
module core_timer_wdog_bench;
  // small configuration: prescale 4, 4-bit counter, tap periods 256..2048
  localparam int PRE_W = 2;
  localparam int CNT_W = 4;
  localparam int RTI_W = 2;
  localparam int BASE_W = PRE_W + CNT_W + RTI_W;
  localparam int CHAIN_MOD = 1 << (BASE_W + 3);
  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [13:0] addr = 14'h0009;
  logic        wr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        ovf, tick, cop_rst;

  int checks = 0;
  int errors = 0;
  int e_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_ni) e_cnt <= 0;
    else         e_cnt <= e_cnt + 1;
  end

  core_timer_wdog #(.PRE_W(PRE_W), .CNT_W(CNT_W), .RTI_W(RTI_W)) u_core_timer_wdog (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ovf_o(ovf),
    .rti_tick_o(tick), .cop_rst_o(cop_rst)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // one reset-to-expiry run; edge numbers count clock edges since reset release
  task automatic run_scn(input string name, input string ctag, input int r0,
                         input int clr_e, input int clr_d, input int rate_e,
                         input int rate_n, input int cw_e, input int exp_x);
    string ttag;
    ttag = (rate_e >= 0) ? "R7" : "R3";
    @(negedge clk);
    rst_ni = 1'b0; wr = 1'b0; addr = 14'h0009;
    @(posedge clk); @(posedge clk);
    @(negedge clk); #1;
    chk(rdata == 8'd0, "R1", {name, " reset counter"}, rdata, 0);
    chk(!ovf && !tick && !cop_rst, "R4", {name, " reset outputs"},
        {ovf, tick, cop_rst}, 0);
    rst_ni = 1'b1;
    forever begin
      int e, cv, sel, nxt, exp_rd;
      bit post;
      e = e_cnt;
      nxt = e + 1;
      wr = 1'b0; addr = 14'h0009; wdata = 8'h00;
      if (nxt == 1)           begin wr = 1'b1; addr = 14'h0008; wdata = 8'(r0); end
      else if (nxt == clr_e)  begin wr = 1'b1; addr = 14'h3FF0; wdata = 8'(clr_d); end
      else if (nxt == rate_e) begin wr = 1'b1; addr = 14'h0008; wdata = 8'(rate_n); end
      else if (nxt == cw_e)   begin wr = 1'b1; addr = 14'h0009; wdata = 8'hFF; end
      #1;
      post = (e >= exp_x);
      cv   = (post ? e - exp_x : e) % CHAIN_MOD;
      if (post)                         sel = 0;
      else if (rate_e >= 0 && e >= rate_e) sel = rate_n;
      else if (e >= 1)                  sel = r0;
      else                              sel = 0;
      if (addr == 14'h0009)      exp_rd = (cv >> PRE_W) % (1 << CNT_W);
      else if (addr == 14'h0008) exp_rd = sel;
      else                       exp_rd = 0;
      chk(int'(rdata) == exp_rd,
          post ? "R8" : (addr == 14'h3FF0) ? "R9" : (addr == 14'h0008) ? "R3" : "R1",
          {name, " read data"}, rdata, exp_rd);
      chk(ovf == ((cv % (1 << (PRE_W + CNT_W))) == (1 << (PRE_W + CNT_W)) - 1),
          "R2", {name, " overflow"}, ovf,
          int'((cv % (1 << (PRE_W + CNT_W))) == (1 << (PRE_W + CNT_W)) - 1));
      chk(tick == (((cv + 1) % (1 << (BASE_W + sel))) == 0), ttag, {name, " tick"},
          tick, int'(((cv + 1) % (1 << (BASE_W + sel))) == 0));
      chk(cop_rst == (e == exp_x), post ? "R8" : ctag, {name, " watchdog pulse"},
          cop_rst, int'(e == exp_x));
      if (e >= exp_x + 8) break;
      @(negedge clk);
    end
  endtask

  initial begin
    // R4: unserviced expiry at 8 tap periods for each rate
    run_scn("rate0", "R4", 0, -1, 0, -1, 0, -1, 2048);
    run_scn("rate1", "R4", 1, -1, 0, -1, 0, -1, 4096);
    run_scn("rate2", "R4", 2, -1, 0, -1, 0, -1, 8192);
    run_scn("rate3", "R4", 3, -1, 0, -1, 0, -1, 16384);
    // R5: service at edge 1001, ignored bit0=1 write at 1500; R9: counter write at 700
    run_scn("service", "R5", 0, 1001, 0, -1, 0, 700, 2816);
    run_scn("svc_bit1", "R5", 0, 1500, 1, -1, 0, -1, 2048);
    // R6: service on the would-be expiring tick edge
    run_scn("collide", "R6", 0, 2048, 0, -1, 0, -1, 4096);
    run_scn("collide_mid", "R6", 0, 768, 0, -1, 0, -1, 2816);
    // R7: rate 0 -> 1 at edge 1001 keeps the three counted ticks
    run_scn("rate_chg", "R7", 0, -1, 0, 1001, 1, -1, 3072);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      summary();
      $finish;
    end
  end
endmodule